// File: doc/BRIEF.md
# Link Bundle Initialization Sequencer

This block brings up an eight-link transceiver in cell mode from the host side. After a start strobe it issues a set order of register writes over a single address/data write port. Each write is held until the port accepts it. The writes configure every channel, set the bundle and mode controls, pulse the soft reset, flag the transmit side as configured, and clear the receive FIFOs through the global reset registers of both halves.

The write stream then pauses and the block watches the per-link good flags. Once every flag is high, it issues one last write that enables automatic bundling. If the flags do not all come high within a parameterized number of cycles, the block raises an error and stops without that write. The done and error flags stay set until the next start.

Top module: `link_bundle_init`

## Requirements
- R1: After reset, wr_valid_o, busy_o, done_o and error_o are all low.
- R2: A start strobe seen at a clock edge makes busy_o and wr_valid_o high from the next cycle. The first NUM_CH writes carry data 0x82 to addresses 0x0100 + 0x10*i, for i = 0 to NUM_CH-1 in ascending order.
- R3: The next writes are issued in this order: 0x1B to 0x0200 (bundle control), 0x01 to 0x0201 (mode), 0x01 then 0x00 to 0x0202 (soft reset), and 0x01 to 0x0203 (transmit configured).
- R4: The FIFO clear follows as four writes in this order: 0x20 to 0x0300 (half A), 0x20 to 0x0310 (half B), 0x00 to 0x0300, and 0x00 to 0x0310.
- R5: A write is transferred on a clock edge where wr_valid_o and wr_ready_i are both high. While wr_valid_o is high and wr_ready_i is low, the valid, address and data outputs hold their values. Each transfer advances the sequence by exactly one step, and only one write is presented at a time.
- R6: The final write, 0x49 to 0x0200, is presented only after a clock edge at which all link_good_i bits are high. While any bit is low, no write beyond the FIFO clear is issued.
- R7: The wait starts at the edge that transfers the last FIFO-clear write. All link-good bits high at any of the following TIMEOUT_CYC edges leads to the final write; at the last of those edges, link-good wins over the timeout. Otherwise, at the TIMEOUT_CYC-th edge error_o rises, busy_o falls, and no further write is issued.
- R8: A start strobe while busy_o is high has no effect on the write sequence or on busy_o.
- R9: After the final write transfers, done_o is high and busy_o is low. done_o stays high until a start strobe, which clears it on the next cycle and begins a new sequence. A start strobe also leaves the error state the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe |
| link_good_i | input | NUM_LINKS | Per-link receive good flags |
| wr_ready_i | input | 1 | Write port accepts the presented write |
| wr_valid_o | output | 1 | A write is presented |
| wr_addr_o | output | ADDR_W | Write address |
| wr_data_o | output | DATA_W | Write data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence completed with the final write |
| error_o | output | 1 | Link-good wait timed out |

## Verification
Busy and the first write are due one cycle after the edge that samples start. Each later write is due in the cycle after the transfer edge of the previous one. The error flag is due exactly TIMEOUT_CYC edges after the transfer edge of the last FIFO-clear write. The bench drives its inputs and samples the outputs at the falling edge. A write is recorded in the half cycle before the rising edge that will transfer it, so every count of edges is taken from that recorded point. The timeout boundary is hit from both sides: links completing at the last allowed edge, and links never completing with the error checked one cycle before and at its due edge. Four ready-stall patterns sweep the hold behaviour.

// File: rtl/lbi_pkg.sv
package lbi_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WRITE, ST_WAIT, ST_FINAL, ST_DONE, ST_FAIL
  } lbi_state_e;

  localparam logic [ADDR_W-1:0] A_CH_BASE   = 16'h0100;
  localparam logic [ADDR_W-1:0] A_CH_STRIDE = 16'h0010;
  localparam logic [ADDR_W-1:0] A_BUNDLE    = 16'h0200;
  localparam logic [ADDR_W-1:0] A_MODE      = 16'h0201;
  localparam logic [ADDR_W-1:0] A_SOFT_RST  = 16'h0202;
  localparam logic [ADDR_W-1:0] A_TX_DONE   = 16'h0203;
  localparam logic [ADDR_W-1:0] A_GRST_A    = 16'h0300;
  localparam logic [ADDR_W-1:0] A_GRST_B    = 16'h0310;

  localparam logic [DATA_W-1:0] D_CH_CFG    = 8'h82;
  localparam logic [DATA_W-1:0] D_BND_INIT  = 8'h1B;
  localparam logic [DATA_W-1:0] D_BND_FINAL = 8'h49;
  localparam logic [DATA_W-1:0] D_CELL8     = 8'h01;
  localparam logic [DATA_W-1:0] D_FIFO_CLR  = 8'h20;

  localparam int N_FIXED = 9;  // writes after the per-channel block
endpackage

// File: rtl/lbi_step_table.sv
module lbi_step_table
  import lbi_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int IDX_W  = 5
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int PRE_N = NUM_CH + N_FIXED;

  logic [IDX_W-1:0] rel;

  always_comb begin
    rel    = idx_i - IDX_W'(NUM_CH);
    addr_o = A_BUNDLE;
    data_o = D_BND_FINAL;
    if (int'(idx_i) < NUM_CH) begin
      addr_o = A_CH_BASE + ADDR_W'(idx_i) * A_CH_STRIDE;
      data_o = D_CH_CFG;
    end else if (int'(idx_i) < PRE_N) begin
      unique case (int'(rel))
        0: begin addr_o = A_BUNDLE;   data_o = D_BND_INIT; end
        1: begin addr_o = A_MODE;     data_o = D_CELL8;    end
        2: begin addr_o = A_SOFT_RST; data_o = 8'h01;      end
        3: begin addr_o = A_SOFT_RST; data_o = 8'h00;      end
        4: begin addr_o = A_TX_DONE;  data_o = 8'h01;      end
        5: begin addr_o = A_GRST_A;   data_o = D_FIFO_CLR; end
        6: begin addr_o = A_GRST_B;   data_o = D_FIFO_CLR; end
        7: begin addr_o = A_GRST_A;   data_o = 8'h00;      end
        default: begin addr_o = A_GRST_B; data_o = 8'h00;  end
      endcase
    end
  end
endmodule

// File: rtl/lbi_link_watch.sv
module lbi_link_watch #(
  parameter int NUM_LINKS   = 8,
  parameter int TIMEOUT_CYC = 1000000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 arm_i,
  input  logic [NUM_LINKS-1:0] link_good_i,
  output logic                 all_good_o,
  output logic                 expired_o
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign all_good_o = &link_good_i;
  assign expired_o  = arm_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!arm_i)            cnt_q <= '0;
    else if (cnt_q != CNT_LAST) cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> cnt_q == '0);
  p_cnt_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i && cnt_q != CNT_LAST |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/link_bundle_init.sv
module link_bundle_init
  import lbi_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int NUM_LINKS   = 8,
  parameter int TIMEOUT_CYC = 1000000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [NUM_LINKS-1:0] link_good_i,
  input  logic                 wr_ready_i,
  output logic                 wr_valid_o,
  output logic [ADDR_W-1:0]    wr_addr_o,
  output logic [DATA_W-1:0]    wr_data_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 error_o
);
  localparam int PRE_N = NUM_CH + N_FIXED;
  localparam int IDX_W = $clog2(PRE_N + 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PRE_N - 1);
  localparam logic [IDX_W-1:0] IDX_FIN  = IDX_W'(PRE_N);

  lbi_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             all_good, expired, xfer;

  lbi_step_table #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_table (
    .idx_i (idx_q),
    .addr_o(wr_addr_o),
    .data_o(wr_data_o)
  );

  lbi_link_watch #(.NUM_LINKS(NUM_LINKS), .TIMEOUT_CYC(TIMEOUT_CYC)) u_watch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (state_q == ST_WAIT),
    .link_good_i(link_good_i),
    .all_good_o (all_good),
    .expired_o  (expired)
  );

  assign wr_valid_o = (state_q == ST_WRITE) || (state_q == ST_FINAL);
  assign xfer       = wr_valid_o && wr_ready_i;
  assign busy_o     = wr_valid_o || (state_q == ST_WAIT);
  assign done_o     = (state_q == ST_DONE);
  assign error_o    = (state_q == ST_FAIL);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      ST_IDLE, ST_DONE, ST_FAIL:
        if (start_i) begin
          state_d = ST_WRITE;
          idx_d   = '0;
        end
      ST_WRITE:
        if (xfer) begin
          if (idx_q == IDX_LAST) begin
            state_d = ST_WAIT;
            idx_d   = IDX_FIN;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      // link-good takes priority over a timeout on the same edge
      ST_WAIT:
        if (all_good)     state_d = ST_FINAL;
        else if (expired) state_d = ST_FAIL;
      ST_FINAL:
        if (xfer) state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o));
  p_final_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_FINAL && $past(state_q) == ST_WAIT |-> $past(&link_good_i));
  p_fail_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> !busy_o && !wr_valid_o && !done_o);
  p_busy_ignore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && !xfer && state_q != ST_WAIT |=> $stable(wr_addr_o) && wr_valid_o);
  p_done_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o && !busy_o);
  p_start_go_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i |=> busy_o && wr_valid_o && !done_o && !error_o);
endmodule

// File: tb/link_bundle_init_tb_top.sv
`timescale 1ns/1ps
module link_bundle_init_tb_top;
  localparam int NCH = 8;
  localparam int NL  = 8;
  localparam int TMO = 20;
  localparam int NW  = NCH + 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [NL-1:0] lg = '0;
  logic          rdy = 1'b0;
  logic          vld, busy, done, err;
  logic [15:0]   addr;
  logic [7:0]    data;

  int checks = 0, fails = 0;
  int wcount = 0, run_id = 0, mon_id = 0, rdy_mode = 0, cyc = 0;
  logic [7:0] lfsr = 8'h5A;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  link_bundle_init #(.NUM_CH(NCH), .NUM_LINKS(NL), .TIMEOUT_CYC(TMO)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .link_good_i(lg),
    .wr_ready_i(rdy), .wr_valid_o(vld), .wr_addr_o(addr), .wr_data_o(data),
    .busy_o(busy), .done_o(done), .error_o(err)
  );

  function automatic logic [15:0] exp_addr(int k);
    if (k < NCH) return 16'h0100 + 16'(k) * 16'h0010;
    case (k - NCH)
      0: return 16'h0200; 1: return 16'h0201; 2: return 16'h0202; 3: return 16'h0202;
      4: return 16'h0203; 5: return 16'h0300; 6: return 16'h0310; 7: return 16'h0300;
      8: return 16'h0310; default: return 16'h0200;
    endcase
  endfunction

  function automatic logic [7:0] exp_data(int k);
    if (k < NCH) return 8'h82;
    case (k - NCH)
      0: return 8'h1B; 1: return 8'h01; 2: return 8'h01; 3: return 8'h00;
      4: return 8'h01; 5: return 8'h20; 6: return 8'h20; 7: return 8'h00;
      8: return 8'h00; default: return 8'h49;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // write monitor: decides ready for the coming edge and records the transfer it implies
  always @(negedge clk) begin
    cyc++;
    if (run_id != mon_id) begin
      wcount = 0;
      mon_id = run_id;
    end
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (rdy_mode)
      0: rdy = 1'b1;
      1: rdy = cyc[0];
      2: rdy = lfsr[0];
      default: rdy = (cyc % 4 == 0);
    endcase
    if (rst_n && vld && rdy) begin
      if (wcount >= NW) chk(1'b0, "R5 extra write", longint'(wcount), longint'(NW));
      else begin
        // R2 R3 R4 R6 order and values
        chk(addr == exp_addr(wcount), "R2/R3/R4/R6 addr", longint'(addr), longint'(exp_addr(wcount)));
        chk(data == exp_data(wcount), "R2/R3/R4/R6 data", longint'(data), longint'(exp_data(wcount)));
      end
      wcount++;
    end
  end

  task automatic go(input int mode, input logic [NL-1:0] links);
    @(negedge clk); #1;
    rdy_mode = mode;
    lg = links;
    run_id++;
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    chk(busy && !done && !err, "R2 busy after start", longint'({busy, done, err}), 64'h4);
  endtask

  task automatic wait_w(input int n);
    while (wcount != n) begin @(negedge clk); #1; end
  endtask

  task automatic wait_done();
    while (!done && !err) begin @(negedge clk); #1; end
    chk(done && !busy && !err, "R9 done", longint'({done, busy, err}), 64'h4);
    chk(wcount == NW, "R5 write count", longint'(wcount), longint'(NW));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!vld && !busy && !done && !err, "R1 reset outputs", longint'({vld, busy, done, err}), 64'h0);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!vld && !busy && !done && !err, "R1 idle", longint'({vld, busy, done, err}), 64'h0);

    // R5: sweep ready patterns with links already good
    for (int m = 0; m < 4; m++) begin
      go(m, '1);
      wait_done();
    end

    // R6: links come up one at a time after the FIFO clear
    go(2, '0);
    wait_w(NW - 1);
    for (int b = 0; b < NL; b++) begin
      repeat (2) @(negedge clk); #1;
      chk(wcount == NW - 1 && busy && !vld, "R6 held while links low",
          longint'(wcount), longint'(NW - 1));
      lg[b] = 1'b1;
    end
    wait_done();

    // R7 boundary: last link arrives exactly at the last allowed edge
    go(0, 8'h7F);
    wait_w(NW - 1);
    repeat (TMO) @(negedge clk); #1;
    chk(!err, "R7 no error before limit", longint'(err), 64'h0);
    lg = '1;
    wait_done();

    // R7: links never complete
    go(1, 8'hFE);
    wait_w(NW - 1);
    repeat (TMO) @(negedge clk); #1;
    chk(!err && busy, "R7 error not yet due", longint'({err, busy}), 64'h1);
    @(negedge clk); #1;
    chk(err && !busy && !done, "R7 error due", longint'({err, busy, done}), 64'h4);
    repeat (10) @(negedge clk); #1;
    chk(err && !vld && wcount == NW - 1, "R7 stopped without final write",
        longint'(wcount), longint'(NW - 1));

    // R8: stray start while busy; R9: restart from error state
    go(3, '1);
    wait_w(5);
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    chk(busy && wcount >= 5 && wcount <= 6, "R8 start ignored while busy", longint'(wcount), 64'h5);
    wait_done();

    // R9: done holds, then clears on the cycle after start
    repeat (10) @(negedge clk); #1;
    chk(done && !busy, "R9 done held", longint'({done, busy}), 64'h2);
    go(0, '1);
    chk(!done, "R9 done cleared by start", longint'(done), 64'h0);
    wait_done();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      chk(1'b0, "watchdog", 64'h0, 64'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule